// File: doc/BRIEF.md
# Critical-Path Sampling Score Counter

This block grades how often a critical datapath under test delivers the right value in time. It drives a probe bit into the head of the path that flips on every clock. It compares whatever arrives at the far end against the bit that was launched for that slot, taking into account the path's latency in clock cycles. Only slots that launched a 1 are graded.

Two counters of equal width run side by side. One counts graded slots and the other counts graded slots that matched. Each time the graded-slot counter wraps, the top bits of the match counter become a score. The score is parked in a shift register and a fresh measurement period starts.

A slow external scan clock, unrelated to the system clock, later shifts the score out one bit at a time while a mode pin holds the block in its readout state. The delay chain itself lives outside the block, and the bench models it as a pipeline with injected bit flips.

Top module: `sample_score`

## Requirements
- R1: `probe_o` is 0 while reset is applied. From the first clock edge after reset it inverts on every rising clock edge, so it becomes 1 on that first edge.
- R2: `capture_i` is graded against the `probe_o` value from `LAT` clock cycles earlier. Only slots whose launched value was 1 are graded. A wrong value that arrives for a launched 0 has no effect on the score.
- R3: The graded-slot counter and the match counter are each `CNT_W` bits wide. The graded-slot counter advances once per graded slot, which is every other cycle. The match counter advances only when `capture_i` is 1 in a graded slot.
- R4: A graded slot that finds the graded-slot counter at all ones wraps that counter. That wrapping slot is not added to the match counter. At the wrap, bits [CNT_W-1 : CNT_W-SNAP_W] of the match counter, which hold the matches among the first 2^CNT_W-1 graded slots of the period, are loaded into the shift register, and the match counter restarts from 0. Each score therefore covers exactly one period.
- R5: `read_mode_i` (0 = count, 1 = readout) passes through a synchronizer of `SYNC_STAGES` flops. While readout is in effect, both counters hold their values and no wrap can load the shift register.
- R6: In readout, `scan_o` presents the shift register's top bit, so the score comes out MSB first. Each rising edge of `scan_clk_i` moves the next bit to `scan_o` and fills the bottom of the register with 0. With no scan edges, `scan_o` holds its value.
- R7: In count mode, edges on `scan_clk_i` leave the stored score untouched.
- R8: A synchronous active-high `rst` clears the toggle, the latency line, both counters and the shift register, so a readout straight after reset yields all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| read_mode_i | input | 1 | Mode select: 0 count, 1 readout (asynchronous) |
| scan_clk_i | input | 1 | External scan clock for readout (asynchronous) |
| capture_i | input | 1 | Value sampled at the far end of the path under test |
| probe_o | output | 1 | Alternating bit launched into the path |
| scan_o | output | 1 | Serial score output, MSB first |

## Verification
The bench sweeps error patterns and computes each expected score arithmetically from the pattern:
- a clean path;
- a path that fails every launched 1;
- a path failing every third launch and every launched 0;
- a path that fails half of every other period.

A misaligned latency line would grade against the wrong slot and score near zero on a clean path. Grading launched 0s would let the flips on 0 slots pull the score down. A match counter that is not cleared at the wrap would report a cumulative count rather than the second period's count.

The bench also holds readout across several would-be wraps and checks that the score is not reloaded. It toggles the scan clock during counting and checks that the score is not shifted away. It reads after reset and checks for zeros, and it checks that zeros fill in behind the last scored bit.

// File: rtl/sample_score_pkg.sv
package sample_score_pkg;

  typedef enum logic {
    MODE_COUNT = 1'b0,
    MODE_READ  = 1'b1
  } score_mode_e;

endpackage

// File: rtl/sample_score_sync.sv
module sample_score_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sample_score_launch.sv
module sample_score_launch #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst,
  output logic probe_o,
  output logic due_o
);

  logic           toggle_q;
  logic [LAT-1:0] line_q;

  always_ff @(posedge clk) begin
    if (rst) toggle_q <= 1'b0;
    else     toggle_q <= ~toggle_q;
  end

  generate
    if (LAT == 1) begin : g_line_single
      always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= toggle_q;
      end
    end else begin : g_line_multi
      always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= {line_q[LAT-2:0], toggle_q};
      end
    end
  endgenerate

  assign probe_o = toggle_q;
  assign due_o   = line_q[LAT-1];

  // R1: the probe flips on every clock once out of reset
  p_probe_flips_r1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> probe_o != $past(probe_o));

endmodule

// File: rtl/sample_score_tally.sv
module sample_score_tally #(
  parameter int CNT_W  = 13,
  parameter int SNAP_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_i,
  input  logic              due_i,
  input  logic              capture_i,
  output logic              load_o,
  output logic [SNAP_W-1:0] snap_o
);

  localparam int SNAP_LSB = CNT_W - SNAP_W;

  logic [CNT_W-1:0]  ref_q;
  logic [CNT_W-1:0]  hit_q;
  logic [SNAP_W-1:0] snap_q;
  logic              load_q;
  logic              graded;
  logic              wrap;
  logic              match;

  assign graded = active_i & due_i;
  assign wrap   = graded & (&ref_q);
  assign match  = graded & capture_i & ~wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= '0;
      hit_q  <= '0;
      snap_q <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= wrap;
      if (graded) ref_q <= ref_q + 1'b1;
      if (wrap) begin
        snap_q <= hit_q[CNT_W-1:SNAP_LSB];
        hit_q  <= '0;
      end else if (match) begin
        hit_q <= hit_q + 1'b1;
      end
    end
  end

  assign load_o = load_q;
  assign snap_o = snap_q;

  // R3: the slot counter moves only on graded slots, by exactly one
  p_ref_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !graded |=> ref_q == $past(ref_q));
  p_ref_step_r3: assert property (@(posedge clk) disable iff (rst)
    graded |=> ref_q == $past(ref_q) + 1'b1);
  // R4: matches never exceed graded slots in a period; a wrap restarts the count
  p_hit_bound_r4: assert property (@(posedge clk) disable iff (rst)
    hit_q <= ref_q);
  p_clear_on_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    wrap |=> hit_q == '0);
  // R4: the score changes only together with a load pulse
  p_snap_only_on_load_r4: assert property (@(posedge clk) disable iff (rst)
    !load_o |-> snap_o == $past(snap_o));

endmodule

// File: rtl/sample_score_readout.sv
module sample_score_readout #(
  parameter int SNAP_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              read_i,
  input  logic              step_i,
  input  logic              load_i,
  input  logic [SNAP_W-1:0] snap_i,
  output logic              scan_o
);

  logic [SNAP_W-1:0] shreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
    end else if (read_i) begin
      if (step_i) shreg_q <= {shreg_q[SNAP_W-2:0], 1'b0};
    end else if (load_i) begin
      shreg_q <= snap_i;
    end
  end

  assign scan_o = shreg_q[SNAP_W-1];

  // R6: with no scan edge in readout, the register holds
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (read_i && !step_i) |=> shreg_q == $past(shreg_q));
  // R5/R7: in count mode only a load may change the register
  p_count_no_shift_r7: assert property (@(posedge clk) disable iff (rst)
    (!read_i && !load_i) |=> shreg_q == $past(shreg_q));
  // R6: a scan edge moves the next bit to the top and fills with 0
  p_shift_r6: assert property (@(posedge clk) disable iff (rst)
    (read_i && step_i) |=> shreg_q == {$past(shreg_q[SNAP_W-2:0]), 1'b0});

endmodule

// File: rtl/sample_score.sv
module sample_score
  import sample_score_pkg::*;
#(
  parameter int CNT_W       = 13,
  parameter int SNAP_W      = 10,
  parameter int LAT         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic read_mode_i,
  input  logic scan_clk_i,
  input  logic capture_i,
  output logic probe_o,
  output logic scan_o
);

  logic              mode_s;
  logic              scan_s;
  logic              scan_prev_q;
  logic              scan_rise;
  logic              due;
  logic              load;
  logic [SNAP_W-1:0] snap;
  score_mode_e       mode;

  sample_score_sync #(.STAGES(SYNC_STAGES)) u_mode_sync (
    .clk (clk), .rst (rst), .d_i (read_mode_i), .q_o (mode_s)
  );

  sample_score_sync #(.STAGES(SYNC_STAGES)) u_scan_sync (
    .clk (clk), .rst (rst), .d_i (scan_clk_i), .q_o (scan_s)
  );

  always_ff @(posedge clk) begin
    if (rst) scan_prev_q <= 1'b0;
    else     scan_prev_q <= scan_s;
  end

  assign scan_rise = scan_s & ~scan_prev_q;
  assign mode      = score_mode_e'(mode_s);

  sample_score_launch #(.LAT(LAT)) u_launch (
    .clk (clk), .rst (rst), .probe_o (probe_o), .due_o (due)
  );

  sample_score_tally #(.CNT_W(CNT_W), .SNAP_W(SNAP_W)) u_tally (
    .clk       (clk),
    .rst       (rst),
    .active_i  (mode == MODE_COUNT),
    .due_i     (due),
    .capture_i (capture_i),
    .load_o    (load),
    .snap_o    (snap)
  );

  sample_score_readout #(.SNAP_W(SNAP_W)) u_readout (
    .clk    (clk),
    .rst    (rst),
    .read_i (mode == MODE_READ),
    .step_i (scan_rise),
    .load_i (load),
    .snap_i (snap),
    .scan_o (scan_o)
  );

  // R5: no load pulse reaches the readout while readout is in effect
  p_no_load_in_read_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_READ && $past(mode) == MODE_READ) |-> !load);

endmodule

// File: tb/sample_score_test.sv
`timescale 1ns/1ps
module sample_score_test;

  localparam int CW  = 6;
  localparam int SW  = 4;
  localparam int LAT = 3;
  localparam int P   = 1 << CW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic read_mode = 1'b0;
  logic scan_clk = 1'b0;
  logic err_now = 1'b0;
  logic capture;
  logic probe;
  logic scan_out;
  logic [LAT-1:0] path_q;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sample_score #(.CNT_W(CW), .SNAP_W(SW), .LAT(LAT), .SYNC_STAGES(2)) uut (
    .clk         (clk),
    .rst         (rst),
    .read_mode_i (read_mode),
    .scan_clk_i  (scan_clk),
    .capture_i   (capture),
    .probe_o     (probe),
    .scan_o      (scan_out)
  );

  // model of the path under test: LAT register stages with an injected flip
  always_ff @(posedge clk) begin
    if (rst) path_q <= '0;
    else     path_q <= {path_q[LAT-2:0], probe ^ err_now};
  end
  assign capture = path_q[LAT-1];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // error decision for the k-th launched 1 after reset
  function automatic logic err_one(input int pat, input int k);
    int per = k / P;
    int pos = k % P;
    case (pat)
      1:       return 1'b1;
      2:       return (k % 3) == 0;
      3:       return (per % 2 == 1) && (pos < P / 2);
      default: return 1'b0;
    endcase
  endfunction

  function automatic int exp_snap(input int pat, input int per);
    int hits = 0;
    for (int j = 0; j < P - 1; j++)
      if (!err_one(pat, per * P + j)) hits++;
    return hits >> (CW - SW);
  endfunction

  task automatic do_reset();
    rst = 1'b1; read_mode = 1'b0; scan_clk = 1'b0; err_now = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic read_score(input string req, input int exp, input int idle);
    scan_clk  = 1'b0;
    read_mode = 1'b1;
    repeat (idle) @(negedge clk);
    for (int b = SW - 1; b >= 0; b--) begin
      chk(req, scan_out, (exp >> b) & 1);
      scan_clk = 1'b1;
      repeat (4) @(negedge clk);
      scan_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
    chk("R6 zero fill", scan_out, 0);
  endtask

  task automatic run_pattern(input int pat, input bit scan_in_count,
                             input int idle, input string req);
    int k = 0;
    int cyc = 0;
    do_reset();
    while (k < 2 * P + P / 2) begin
      @(negedge clk);
      if (probe) begin
        err_now = err_one(pat, k);
        k++;
      end else begin
        err_now = (pat == 2);
      end
      if (scan_in_count) scan_clk = cyc[2];
      cyc++;
    end
    err_now = 1'b0;
    read_score(req, exp_snap(pat, 1), idle);
  endtask

  initial begin
    // R8 / R1: reset state and alternation
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 probe in reset", probe, 0);
    chk("R8 scan_o in reset", scan_out, 0);
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R1 probe alternation", probe, (i % 2 == 0) ? 1 : 0);
    end

    // R3 R4: clean path scores full scale
    run_pattern(0, 1'b0, 6, "R4 clean path score");
    // R8: reset after a non-zero score reads back as zero
    do_reset();
    read_score("R8 score after reset", 0, 6);
    // R3: every launched 1 fails
    run_pattern(1, 1'b0, 6, "R3 all-fail score");
    // R2: every third launch fails, every launched 0 is also flipped
    run_pattern(2, 1'b0, 6, "R2 zero-launch flips ignored");
    // R4 R5: half of odd periods fail; readout held over three would-be wraps
    run_pattern(3, 1'b0, 6 * P, "R5 no reload in readout");
    // R7: scan clock toggling while counting leaves the score intact
    run_pattern(0, 1'b1, 6, "R7 scan ignored in count");
    // R6: readout of a mixed score
    run_pattern(2, 1'b1, 20, "R6 MSB-first readout");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule